// File: doc/BRIEF.md
# Bus-Master Snoop Coherency Controller

When a peripheral bus master reads or writes main memory, this block keeps the processor's first-level cache, the second-level cache and DRAM coherent. A master request gives a start address, a direction and a "transfer continues" level. The block then issues a snoop for each cache line in turn. For every line it puts the line-aligned address on the snoop address output and pulses a strobe. That same strobe starts the second-level tag lookup. The combined cache-enable/invalidate pin goes low for reads and high for writes. Two clocks after the strobe, the block samples the processor's hit-to-modified response together with the second-level hit and modified flags.

From those three flags and the direction, the block chooses a result. It may request a write-back from the first-level or the second-level cache into the posted-write buffer, invalidate the second-level line, or do neither. The master is released to DRAM for that line only after any write-back is retired. While the master keeps its transfer going, the block snoops the next 32-byte line on its own, so bursts can cross line boundaries. If the transfer has ended before a look-ahead snoop reaches its sample point, that snoop's result is dropped.

Top module: `snoop_coherency_ctrl`

## Requirements
- R1: After reset, `snp_strobe`, `wb_req`, `mem_go` and `l2_inv` are 0 and `cen_inv` is 1.
- R2: A `req_start` accepted while idle gives a one-cycle `snp_strobe` in the next cycle, with `snp_addr` equal to `req_addr` with its low 5 bits cleared.
- R3: While `snp_strobe` is high, `cen_inv` equals the latched direction: 0 for a master read (`req_write`=0) and 1 for a master write.
- R4: On a read where `l1_hitm` is 1, `wb_req` is raised with `wb_src`=0 (first level), and `l2_inv` pulses only if `l2_hit` is 1.
- R5: On a read where `l1_hitm` is 0 and both `l2_hit` and `l2_mod` are 1, `wb_req` is raised with `wb_src`=1 (second level), and `l2_inv` stays 0.
- R6: On a write, `l2_inv` pulses whenever `l2_hit` is 1. A write-back is requested if `l1_hitm` is 1 or if both `l2_hit` and `l2_mod` are 1, with `wb_src`=0 whenever `l1_hitm` is 1.
- R7: When no write-back is needed, `mem_go` pulses for one cycle, three cycles after the strobe. `wb_req` and `l2_inv` report the decision in the cycle after the sample.
- R8: `wb_req` stays high until `wb_done` is seen. `mem_go` pulses in the cycle after that and never while a write-back is still pending.
- R9: If `req_active` is 1 in the `mem_go` cycle, the next strobe follows in the very next cycle, with `snp_addr` increased by 32.
- R10: If `req_active` is 0 at the sample point of a look-ahead snoop, no `wb_req`, `l2_inv` or `mem_go` results, and the block returns to idle.
- R11: A `req_start` that arrives while a snoop is in progress is ignored: no further strobe follows the transfer.
- R12: `l1_hitm`, `l2_hit` and `l2_mod` are used only in the cycle exactly two clocks after the strobe. Their values in other cycles have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_start | input | 1 | Master request pulse |
| req_addr | input | 32 | Master start address |
| req_write | input | 1 | 1 = master write, 0 = master read |
| req_active | input | 1 | Master transfer continues past the current line |
| snp_strobe | output | 1 | Snoop address strobe, also starts the second-level tag lookup |
| snp_addr | output | 32 | Line-aligned snoop address, also the write-back line address |
| cen_inv | output | 1 | Cache-enable/invalidate pin level |
| l1_hitm | input | 1 | Processor hit-to-modified response |
| l2_hit | input | 1 | Second-level tag hit |
| l2_mod | input | 1 | Second-level line is modified |
| l2_inv | output | 1 | One-cycle pulse that invalidates the second-level line |
| wb_req | output | 1 | Write-back request to the posted-write buffer |
| wb_src | output | 1 | Write-back source: 0 = first level, 1 = second level |
| wb_done | input | 1 | Write-back retired |
| mem_go | output | 1 | One-cycle pulse that releases the master access for this line |

## Verification
A wrong decision register shows up one cycle after the sample point, as a wrong `wb_req`, `wb_src` or `l2_inv`. A sequencer out of step moves the `mem_go` pulse, or lets it appear while `wb_req` is still high. A line address that was not advanced or not aligned shows up on `snp_addr` in the strobe cycle of the look-ahead snoop. A lost "first line" flag shows up as a look-ahead result that is acted on after the master has stopped. The sweep drives deliberately inverted response values outside the sample cycle, so sampling in the wrong cycle changes the decision at once.

// File: rtl/snp_pkg.sv
package snp_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_STROBE,
    ST_WAIT,
    ST_SAMPLE,
    ST_WB,
    ST_GRANT
  } snp_state_e;

  localparam logic SRC_L1 = 1'b0;
  localparam logic SRC_L2 = 1'b1;

  typedef struct packed {
    logic wb;
    logic src;
    logic l2_inv;
  } snp_action_t;

  // Coherency rules for one sampled snoop result.
  function automatic snp_action_t resolve(input logic is_wr, input logic hitm,
                                          input logic l2h, input logic l2m);
    snp_action_t a;
    logic l2_dirty;
    l2_dirty = l2h & l2m;
    a.wb     = hitm | l2_dirty;
    a.src    = hitm ? SRC_L1 : SRC_L2;
    a.l2_inv = is_wr ? l2h : (hitm & l2h);
    return a;
  endfunction

endpackage

// File: rtl/snp_line_addr.sv
module snp_line_addr #(
  parameter int AW         = 32,
  parameter int LINE_BYTES = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          advance,
  input  logic [AW-1:0] base_in,
  output logic [AW-1:0] line_addr
);
  localparam int OFS = $clog2(LINE_BYTES);

  function automatic logic [AW-1:0] align_down(input logic [AW-1:0] a);
    return {a[AW-1:OFS], {OFS{1'b0}}};
  endfunction

  function automatic logic [AW-1:0] next_line(input logic [AW-1:0] a);
    return a + AW'(LINE_BYTES);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)       line_addr <= '0;
    else if (load)    line_addr <= align_down(base_in);
    else if (advance) line_addr <= next_line(line_addr);
  end
endmodule

// File: rtl/snp_seq.sv
module snp_seq
  import snp_pkg::*;
#(
  parameter int SAMPLE_GAP = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_start,
  input  logic req_write,
  input  logic req_active,
  input  logic need_wb,
  input  logic wb_done,
  output logic load,
  output logic advance,
  output logic strobe,
  output logic sample_evt,
  output logic discard_evt,
  output logic idle,
  output logic wb_req,
  output logic mem_go,
  output logic wr_flag
);
  localparam int CW = $clog2(SAMPLE_GAP + 1);

  snp_state_e      st, st_nx;
  logic [CW-1:0]   gap_cnt;
  logic            first_line;

  assign idle        = (st == ST_IDLE);
  assign strobe      = (st == ST_STROBE);
  assign sample_evt  = (st == ST_SAMPLE);
  assign discard_evt = sample_evt && !first_line && !req_active;
  assign wb_req      = (st == ST_WB);
  assign mem_go      = (st == ST_GRANT);
  assign load        = idle && req_start;
  assign advance     = mem_go && req_active;

  always_comb begin
    st_nx = st;
    unique case (st)
      ST_IDLE:   if (req_start) st_nx = ST_STROBE;
      ST_STROBE: st_nx = (SAMPLE_GAP <= 1) ? ST_SAMPLE : ST_WAIT;
      ST_WAIT:   if (gap_cnt == CW'(SAMPLE_GAP - 1)) st_nx = ST_SAMPLE;
      ST_SAMPLE: begin
        if (discard_evt)  st_nx = ST_IDLE;
        else if (need_wb) st_nx = ST_WB;
        else              st_nx = ST_GRANT;
      end
      ST_WB:     if (wb_done) st_nx = ST_GRANT;
      ST_GRANT:  st_nx = req_active ? ST_STROBE : ST_IDLE;
      default:   st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      gap_cnt    <= '0;
      first_line <= 1'b0;
      wr_flag    <= 1'b0;
    end else begin
      st <= st_nx;
      if (st == ST_STROBE)    gap_cnt <= CW'(1);
      else if (st == ST_WAIT) gap_cnt <= gap_cnt + CW'(1);
      if (load) begin
        first_line <= 1'b1;
        wr_flag    <= req_write;
      end else if (mem_go) begin
        first_line <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/snp_decide.sv
module snp_decide
  import snp_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sample_evt,
  input  logic discard_evt,
  input  logic is_wr,
  input  logic l1_hitm,
  input  logic l2_hit,
  input  logic l2_mod,
  output logic need_wb,
  output logic src_q,
  output logic inv_q
);
  snp_action_t act;

  assign act     = resolve(is_wr, l1_hitm, l2_hit, l2_mod);
  assign need_wb = act.wb;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_q <= SRC_L1;
      inv_q <= 1'b0;
    end else begin
      inv_q <= sample_evt && !discard_evt && act.l2_inv;
      if (sample_evt && !discard_evt) src_q <= act.src;
    end
  end
endmodule

// File: rtl/snoop_coherency_ctrl.sv
module snoop_coherency_ctrl #(
  parameter int AW         = 32,
  parameter int LINE_BYTES = 32,
  parameter int SAMPLE_GAP = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_start,
  input  logic [AW-1:0] req_addr,
  input  logic          req_write,
  input  logic          req_active,
  output logic          snp_strobe,
  output logic [AW-1:0] snp_addr,
  output logic          cen_inv,
  input  logic          l1_hitm,
  input  logic          l2_hit,
  input  logic          l2_mod,
  output logic          l2_inv,
  output logic          wb_req,
  output logic          wb_src,
  input  logic          wb_done,
  output logic          mem_go
);
  logic load, advance, sample_evt, discard_evt, seq_idle, need_wb, wr_flag;

  snp_line_addr #(.AW(AW), .LINE_BYTES(LINE_BYTES)) u_addr (
    .clk(clk), .rst_n(rst_n), .load(load), .advance(advance),
    .base_in(req_addr), .line_addr(snp_addr)
  );

  snp_seq #(.SAMPLE_GAP(SAMPLE_GAP)) u_seq (
    .clk(clk), .rst_n(rst_n), .req_start(req_start), .req_write(req_write),
    .req_active(req_active), .need_wb(need_wb), .wb_done(wb_done),
    .load(load), .advance(advance), .strobe(snp_strobe),
    .sample_evt(sample_evt), .discard_evt(discard_evt), .idle(seq_idle),
    .wb_req(wb_req), .mem_go(mem_go), .wr_flag(wr_flag)
  );

  snp_decide u_dec (
    .clk(clk), .rst_n(rst_n), .sample_evt(sample_evt), .discard_evt(discard_evt),
    .is_wr(wr_flag), .l1_hitm(l1_hitm), .l2_hit(l2_hit), .l2_mod(l2_mod),
    .need_wb(need_wb), .src_q(wb_src), .inv_q(l2_inv)
  );

  // Pin rests high (inactive); during a strobe it carries the direction.
  assign cen_inv = snp_strobe ? wr_flag : 1'b1;
endmodule

// File: rtl/snp_chk.sv
module snp_chk #(
  parameter int AW         = 32,
  parameter int LINE_BYTES = 32,
  parameter int SAMPLE_GAP = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_start,
  input logic          seq_idle,
  input logic          snp_strobe,
  input logic [AW-1:0] snp_addr,
  input logic          sample_evt,
  input logic          discard_evt,
  input logic          mem_go,
  input logic          wb_req,
  input logic          wb_done,
  input logic          l2_inv
);
  localparam int CW = $clog2(SAMPLE_GAP + 2);
  logic [CW-1:0] since_strobe;

  always_ff @(posedge clk) begin
    if (!rst_n)                              since_strobe <= '0;
    else if (snp_strobe)                     since_strobe <= CW'(1);
    else if (since_strobe != '1)             since_strobe <= since_strobe + CW'(1);
  end

  // R2
  start_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seq_idle && req_start |=> snp_strobe);

  // R2
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    snp_strobe |=> !snp_strobe);

  // R12
  sample_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample_evt |-> since_strobe == CW'(SAMPLE_GAP));

  // R8
  wb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_req && !wb_done |=> wb_req);

  // R8
  grant_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_go |-> ($past(sample_evt) || $past(wb_req && wb_done)));

  // R9
  ahead_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    snp_strobe && $past(mem_go) |-> snp_addr == $past(snp_addr) + AW'(LINE_BYTES));

  // R10
  discard_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    discard_evt |=> !l2_inv && !wb_req && !mem_go && seq_idle);
endmodule

bind snoop_coherency_ctrl snp_chk #(
  .AW(AW), .LINE_BYTES(LINE_BYTES), .SAMPLE_GAP(SAMPLE_GAP)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_start(req_start), .seq_idle(seq_idle),
  .snp_strobe(snp_strobe), .snp_addr(snp_addr), .sample_evt(sample_evt),
  .discard_evt(discard_evt), .mem_go(mem_go), .wb_req(wb_req),
  .wb_done(wb_done), .l2_inv(l2_inv)
);

// File: tb/tb_snoop_coherency_ctrl.sv
module tb_snoop_coherency_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_start, req_write, req_active;
  logic [31:0] req_addr;
  logic        snp_strobe, cen_inv, l2_inv, wb_req, wb_src, mem_go;
  logic [31:0] snp_addr;
  logic        l1_hitm, l2_hit, l2_mod, wb_done;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  snoop_coherency_ctrl dut (
    .clk(clk), .rst_n(rst_n), .req_start(req_start), .req_addr(req_addr),
    .req_write(req_write), .req_active(req_active), .snp_strobe(snp_strobe),
    .snp_addr(snp_addr), .cen_inv(cen_inv), .l1_hitm(l1_hitm), .l2_hit(l2_hit),
    .l2_mod(l2_mod), .l2_inv(l2_inv), .wb_req(wb_req), .wb_src(wb_src),
    .wb_done(wb_done), .mem_go(mem_go)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  // One single-line transfer with the responses valid only in the sample cycle.
  task automatic one_line(input bit wr, input bit hm, input bit h2, input bit m2,
                          input logic [31:0] a);
    bit exp_wb, exp_src, exp_inv;
    exp_wb  = 1'b0; exp_src = 1'b0; exp_inv = 1'b0;
    if (hm) begin
      exp_wb = 1'b1; exp_src = 1'b0;
      exp_inv = h2;
    end else if (h2 && m2) begin
      exp_wb = 1'b1; exp_src = 1'b1;
      exp_inv = wr;
    end else begin
      exp_inv = wr && h2;
    end

    req_start = 1'b1; req_addr = a; req_write = wr; req_active = 1'b0;
    tick();                                  // STROBE
    check("R2 strobe", 32'(snp_strobe), 32'd1);
    check("R2 addr", snp_addr, a & ~32'h1f);
    check("R3 cen_inv", 32'(cen_inv), 32'(wr));
    req_addr = ~a; req_write = ~wr;          // R11: start while busy
    l1_hitm = ~hm; l2_hit = ~h2; l2_mod = ~m2;
    tick();                                  // WAIT
    req_start = 1'b0;
    check("R2 one-cycle strobe", 32'(snp_strobe), 32'd0);
    tick();                                  // SAMPLE
    l1_hitm = hm; l2_hit = h2; l2_mod = m2;
    tick();                                  // decision visible
    l1_hitm = ~hm; l2_hit = ~h2; l2_mod = ~m2;
    check(wr ? "R6 l2_inv" : "R4/R5 l2_inv", 32'(l2_inv), 32'(exp_inv));
    check("R12 wb_req", 32'(wb_req), 32'(exp_wb));
    check("R7 mem_go", 32'(mem_go), 32'(!exp_wb));
    if (exp_wb) begin
      check(wr ? "R6 wb_src" : "R4/R5 wb_src", 32'(wb_src), 32'(exp_src));
      tick();
      check("R8 wb held", 32'(wb_req), 32'd1);
      check("R8 no early go", 32'(mem_go), 32'd0);
      wb_done = 1'b1;
      tick();
      wb_done = 1'b0;
      check("R8 go after done", 32'(mem_go), 32'd1);
      check("R8 wb dropped", 32'(wb_req), 32'd0);
    end
    tick();
    check("R11 no extra strobe", 32'(snp_strobe), 32'd0);
    check("R11 cen idle", 32'(cen_inv), 32'd1);
    l1_hitm = 1'b0; l2_hit = 1'b0; l2_mod = 1'b0;
  endtask

  initial begin : wdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req_start = 1'b0; req_addr = '0; req_write = 1'b0;
    req_active = 1'b0; l1_hitm = 1'b0; l2_hit = 1'b0; l2_mod = 1'b0; wb_done = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1
    check("R1 strobe", 32'(snp_strobe), 32'd0);
    check("R1 wb_req", 32'(wb_req), 32'd0);
    check("R1 mem_go", 32'(mem_go), 32'd0);
    check("R1 l2_inv", 32'(l2_inv), 32'd0);
    check("R1 cen_inv", 32'(cen_inv), 32'd1);

    for (int c = 0; c < 16; c++) begin
      one_line(c[3], c[2], c[1], c[0], 32'h4000_0005 + 32'(c) * 32'd77);
    end

    // R9 look-ahead then R10 discard
    req_start = 1'b1; req_addr = 32'h0000_1fe7; req_write = 1'b0; req_active = 1'b1;
    tick();
    req_start = 1'b0;
    check("R9 first addr", snp_addr, 32'h0000_1fe0);
    tick(); tick(); tick();                  // WAIT, SAMPLE, GRANT
    check("R9 first go", 32'(mem_go), 32'd1);
    tick();
    check("R9 ahead strobe", 32'(snp_strobe), 32'd1);
    check("R9 ahead addr", snp_addr, 32'h0000_2000);
    req_active = 1'b0; l1_hitm = 1'b1; l2_hit = 1'b1; l2_mod = 1'b1;
    tick(); tick(); tick();                  // WAIT, SAMPLE, after
    check("R10 no inv", 32'(l2_inv), 32'd0);
    check("R10 no wb", 32'(wb_req), 32'd0);
    check("R10 no go", 32'(mem_go), 32'd0);
    tick();
    check("R10 idle", 32'(snp_strobe), 32'd0);
    l1_hitm = 1'b0; l2_hit = 1'b0; l2_mod = 1'b0;

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule